// File: doc/BRIEF.md
# Banked Data Memory with Pointer Access

This block is the data-memory side of a small 8-bit processor core. Each access names a 7-bit offset within a bank. The bank comes from a bank-number register, and together they form a 12-bit linear address over 32 banks of 128 bytes. Every bank has the same layout:

- Offsets 0x00 to 0x0B hold the twelve core registers, which are the same registers in every bank.
- Offsets 0x0C to 0x1F are peripheral register slots, served through a simple peripheral port.
- Offsets 0x20 to 0x6F are general-purpose RAM. Only the first `GPR_BANKS` banks have this RAM.
- Offsets 0x70 to 0x7F are sixteen bytes of shared RAM, the same bytes from every bank.

Two 16-bit pointers, each kept as a low byte and a high byte in the core registers, give indirect access through two data-window offsets. Bit 15 of a pointer selects program memory instead of data memory. A read through such a pointer fetches the low byte of a program word on a read port and holds off the core for one extra cycle. A write through such a pointer is dropped.

Read results are registered. A data read returns its byte one cycle after it is accepted. A program-memory read returns its byte one cycle after its stall cycle.

Top module: `banked_dmem`

## Requirements
- R1: A direct access targets linear address {bank[4:0], offset}. General-purpose bytes at offsets 0x20–0x6F of banks below `GPR_BANKS` (default 4) are separate storage per bank. A read returns the last byte written to that address.
- R2: Offsets 0x00–0x0B reach the same core registers from every bank. In offset order they are: window 0, window 1, program-counter low, status, pointer-0 low, pointer-0 high, pointer-1 low, pointer-1 high, bank number, accumulator, program-counter high, interrupt control.
- R3: Offsets 0x70–0x7F reach the same 16 bytes from every bank.
- R4: An access to offsets 0x0C–0x1F raises `per_en` in the same cycle, with `per_addr` set to the 12-bit linear address. A write also raises `per_we` with `per_wdata` set to the write byte. A read returns `per_rdata`. `per_en` is low for every other access.
- R5: Reads of unimplemented locations return 0, and writes to them change nothing. The general-purpose offsets of banks at or above `GPR_BANKS` are unimplemented. The bank-number register keeps only its low 5 bits, and its upper 3 bits read as 0.
- R6: An access at offset 0x00 or 0x01 goes through pointer 0 or pointer 1. When pointer bit 15 is clear, the target is the pointer's low 12 bits, decoded as in R1–R5. A pointer that targets offset 0x00 or 0x01 of any bank reads 0 and ignores writes.
- R7: When pointer bit 15 is set, a window read drives `pm_addr` with pointer bits 14:0 and returns `pm_rdata[7:0]`.
- R8: When pointer bit 15 is set, a window write is discarded. It changes no storage and raises neither `per_en` nor `stall`.
- R9: A program-memory read raises `stall` for exactly the cycle after it is accepted. `rd_valid` follows in the next cycle. Any request presented while `stall` is high is ignored.
- R10: After reset all storage and outputs are 0. An accepted data read gives `rd_valid` high with its byte in the following cycle. `rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 7 | In-bank offset |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| stall | output | 1 | Program-memory read in progress |
| per_en | output | 1 | Peripheral slot access |
| per_we | output | 1 | Peripheral slot write |
| per_addr | output | 12 | Peripheral slot linear address |
| per_wdata | output | 8 | Peripheral write byte |
| per_rdata | input | 8 | Peripheral read byte |
| pm_addr | output | 15 | Program-memory word address |
| pm_rdata | input | 14 | Program-memory word |

## Verification
The directed patterns are chosen so that each one tells a different fault apart:

- The same offset is written from two banks. This separates per-bank storage from mirrored storage.
- Core and shared bytes are written in one bank and read in others. This shows whether the mirroring holds.
- Pointers are aimed at general RAM, at peripheral slots, at the window offsets themselves and at program memory. This checks the indirect decode, the zero read and the dropped write.
- A request is held during a stall, then the location it would have written is read back.

A long random run then mixes bank changes, pointer rewrites and every region against a behavioural model.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CORE,
        RG_SFR,
        RG_GPR,
        RG_COMMON
    } region_e;

    localparam int NUM_CORE  = 12;
    localparam int SFR_BASE  = 12;
    localparam int GPR_BASE  = 32;
    localparam int COM_BASE  = 112;
    localparam int GPR_BYTES = COM_BASE - GPR_BASE;
    localparam int COM_BYTES = 16;

    localparam logic [3:0] CR_WIN0    = 4'd0;
    localparam logic [3:0] CR_WIN1    = 4'd1;
    localparam logic [3:0] CR_PCLO    = 4'd2;
    localparam logic [3:0] CR_STAT    = 4'd3;
    localparam logic [3:0] CR_P0_LO   = 4'd4;
    localparam logic [3:0] CR_P0_HI   = 4'd5;
    localparam logic [3:0] CR_P1_LO   = 4'd6;
    localparam logic [3:0] CR_P1_HI   = 4'd7;
    localparam logic [3:0] CR_BANK    = 4'd8;
    localparam logic [3:0] CR_ACCU    = 4'd9;
    localparam logic [3:0] CR_PCHI    = 4'd10;
    localparam logic [3:0] CR_IRQCTL  = 4'd11;

endpackage

// File: rtl/dmem_addr_dec.sv
module dmem_addr_dec
    import dmem_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int OFF_W     = 7,
    parameter int GPR_BANKS = 4,
    parameter int GPR_IDX_W = 9
) (
    input  logic [BANK_W+OFF_W-1:0] addr,
    output region_e                 region,
    output logic [3:0]              core_idx,
    output logic [3:0]              com_idx,
    output logic [GPR_IDX_W-1:0]    gpr_idx
);

    logic [OFF_W-1:0]  off;
    logic [BANK_W-1:0] bank;

    assign off      = addr[OFF_W-1:0];
    assign bank     = addr[BANK_W+OFF_W-1:OFF_W];
    assign core_idx = off[3:0];
    assign com_idx  = off[3:0];
    assign gpr_idx  = GPR_IDX_W'(int'(bank) * GPR_BYTES + int'(off) - GPR_BASE);

    always_comb begin
        if (int'(off) < SFR_BASE) begin
            region = RG_CORE;
        end else if (int'(off) < GPR_BASE) begin
            region = RG_SFR;
        end else if (int'(off) < COM_BASE) begin
            region = (int'(bank) < GPR_BANKS) ? RG_GPR : RG_NONE;
        end else begin
            region = RG_COMMON;
        end
    end

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
    import dmem_pkg::*;
#(
    parameter int GPR_WORDS = 320,
    parameter int GPR_IDX_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gpr_we,
    input  logic [GPR_IDX_W-1:0] gpr_idx,
    input  logic                 com_we,
    input  logic [3:0]           com_idx,
    input  logic [7:0]           wdata,
    output logic [7:0]           gpr_rdata,
    output logic [7:0]           com_rdata
);

    typedef struct packed {
        logic [GPR_WORDS-1:0][7:0] gpr;
        logic [COM_BYTES-1:0][7:0] com;
    } ram_t;

    ram_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gpr_we) begin
            st_d.gpr[gpr_idx] = wdata;
        end
        if (com_we) begin
            st_d.com[com_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gpr_rdata = st_q.gpr[gpr_idx];
    assign com_rdata = st_q.com[com_idx];

endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
    import dmem_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int OFF_W     = 7,
    parameter int GPR_BANKS = 4,
    parameter int PTR_W     = 16,
    parameter int PM_W      = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [OFF_W-1:0]        acc_offset,
    input  logic [7:0]              acc_wdata,
    output logic                    rd_valid,
    output logic [7:0]              rd_data,
    output logic                    stall,
    output logic                    per_en,
    output logic                    per_we,
    output logic [BANK_W+OFF_W-1:0] per_addr,
    output logic [7:0]              per_wdata,
    input  logic [7:0]              per_rdata,
    output logic [PTR_W-2:0]        pm_addr,
    input  logic [PM_W-1:0]         pm_rdata
);

    localparam int ADDR_W    = BANK_W + OFF_W;
    localparam int GPR_WORDS = GPR_BANKS * GPR_BYTES;
    localparam int GPR_IDX_W = (GPR_WORDS > 1) ? $clog2(GPR_WORDS) : 1;

    typedef struct packed {
        logic [NUM_CORE-1:0][7:0] core;
        logic [7:0]               rdata;
        logic                     rvalid;
        logic                     pm_wait;
        logic [PTR_W-2:0]         pm_addr;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0]    dec_addr   [2];
    region_e              dec_region [2];
    logic [3:0]           dec_core   [2];
    logic [3:0]           dec_com    [2];
    logic [GPR_IDX_W-1:0] dec_gpr    [2];

    logic [PTR_W-1:0]     ptr;
    logic                 accept, is_win, pm_tgt;
    region_e              eff_region;
    logic [3:0]           eff_core, eff_com;
    logic [GPR_IDX_W-1:0] eff_gpr;
    logic [7:0]           gpr_rdata, com_rdata, rd_mux;
    logic                 unused_pm_hi;

    assign accept      = acc_valid && !st_q.pm_wait;
    assign ptr         = acc_offset[0] ? {st_q.core[CR_P1_HI], st_q.core[CR_P1_LO]}
                                       : {st_q.core[CR_P0_HI], st_q.core[CR_P0_LO]};
    assign dec_addr[0] = {st_q.core[CR_BANK][BANK_W-1:0], acc_offset};
    assign dec_addr[1] = ptr[ADDR_W-1:0];

    // 0: direct address, 1: pointer target
    for (genvar g = 0; g < 2; g++) begin : g_dec
        dmem_addr_dec #(
            .BANK_W   (BANK_W),
            .OFF_W    (OFF_W),
            .GPR_BANKS(GPR_BANKS),
            .GPR_IDX_W(GPR_IDX_W)
        ) u_dec (
            .addr    (dec_addr[g]),
            .region  (dec_region[g]),
            .core_idx(dec_core[g]),
            .com_idx (dec_com[g]),
            .gpr_idx (dec_gpr[g])
        );
    end

    always_comb begin
        is_win   = (dec_region[0] == RG_CORE) && (dec_core[0][3:1] == 3'd0);
        pm_tgt   = is_win && ptr[PTR_W-1];
        eff_core = is_win ? dec_core[1] : dec_core[0];
        eff_com  = is_win ? dec_com[1]  : dec_com[0];
        eff_gpr  = is_win ? dec_gpr[1]  : dec_gpr[0];
        if (!is_win) begin
            eff_region = dec_region[0];
        end else if (pm_tgt) begin
            eff_region = RG_NONE;
        end else if (dec_region[1] == RG_CORE && dec_core[1][3:1] == 3'd0) begin
            eff_region = RG_NONE;
        end else begin
            eff_region = dec_region[1];
        end
    end

    always_comb begin
        unique case (eff_region)
            RG_CORE:   rd_mux = st_q.core[eff_core];
            RG_SFR:    rd_mux = per_rdata;
            RG_GPR:    rd_mux = gpr_rdata;
            RG_COMMON: rd_mux = com_rdata;
            default:   rd_mux = 8'h00;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = 1'b0;
        st_d.pm_wait = 1'b0;
        if (st_q.pm_wait) begin
            st_d.rdata  = pm_rdata[7:0];
            st_d.rvalid = 1'b1;
        end else if (accept) begin
            if (!acc_write) begin
                if (pm_tgt) begin
                    st_d.pm_wait = 1'b1;
                    st_d.pm_addr = ptr[PTR_W-2:0];
                end else begin
                    st_d.rdata  = rd_mux;
                    st_d.rvalid = 1'b1;
                end
            end else if (eff_region == RG_CORE) begin
                if (eff_core == CR_BANK) begin
                    st_d.core[eff_core] = {{(8-BANK_W){1'b0}}, acc_wdata[BANK_W-1:0]};
                end else begin
                    st_d.core[eff_core] = acc_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dmem_ram #(
        .GPR_WORDS(GPR_WORDS),
        .GPR_IDX_W(GPR_IDX_W)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpr_we   (accept && acc_write && eff_region == RG_GPR),
        .gpr_idx  (eff_gpr),
        .com_we   (accept && acc_write && eff_region == RG_COMMON),
        .com_idx  (eff_com),
        .wdata    (acc_wdata),
        .gpr_rdata(gpr_rdata),
        .com_rdata(com_rdata)
    );

    assign per_en       = accept && (eff_region == RG_SFR);
    assign per_we       = per_en && acc_write;
    assign per_addr     = is_win ? dec_addr[1] : dec_addr[0];
    assign per_wdata    = acc_wdata;
    assign rd_valid     = st_q.rvalid;
    assign rd_data      = st_q.rdata;
    assign stall        = st_q.pm_wait;
    assign pm_addr      = st_q.pm_addr;
    assign unused_pm_hi = ^pm_rdata[PM_W-1:8];

endmodule

// File: rtl/dmem_checker.sv
module dmem_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic        stall,
    input logic        per_en,
    input logic        per_we,
    input logic [11:0] per_addr,
    input logic [13:0] pm_rdata
);

    AST_PER_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        per_we |-> per_en); // R4

    AST_PER_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> (per_addr[6:0] >= 7'h0C && per_addr[6:0] <= 7'h1F)); // R4

    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R9

    AST_PM_DATA_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (rd_valid && rd_data == $past(pm_rdata[7:0]))); // R7

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !stall) |=> (rd_valid || stall)); // R10

    AST_WRITE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !stall) |=> (!rd_valid && !stall)); // R8

    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(acc_valid && !acc_write && !stall) || $past(stall))); // R10

endmodule

bind banked_dmem dmem_checker u_dmem_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .stall    (stall),
    .per_en   (per_en),
    .per_we   (per_we),
    .per_addr (per_addr),
    .pm_rdata (pm_rdata)
);

// File: tb/test_banked_dmem.sv
module test_banked_dmem;

    localparam int GPR_BANKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [6:0]  acc_offset = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid, stall, per_en, per_we;
    logic [7:0]  rd_data, per_wdata, per_rdata;
    logic [11:0] per_addr;
    logic [14:0] pm_addr;
    logic [13:0] pm_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    // bench-side peripheral and program memory
    assign per_rdata = per_addr[7:0] ^ {per_addr[11:7], 3'b101};
    assign pm_rdata  = {pm_addr[14:9], pm_addr[7:0] + {1'b0, pm_addr[14:8]}};

    banked_dmem i_banked_dmem (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .stall(stall), .per_en(per_en), .per_we(per_we),
        .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
        .pm_addr(pm_addr), .pm_rdata(pm_rdata)
    );

    // reference model state
    logic [7:0] m_core [12];
    logic [7:0] m_com  [16];
    logic [7:0] m_gpr  [GPR_BANKS*80];

    function automatic logic [7:0] per_val(int a);
        return 8'((a & 255) ^ ((((a >> 7) & 31) << 3) | 5));
    endfunction

    function automatic logic [7:0] pm_val(int p);
        return 8'((p & 255) + ((p >> 8) & 127));
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, expv);
        end
    endtask

    task automatic model(input bit wr, input int off, input logic [7:0] d,
                         output bit is_pm, output bit has_per, output int per_a,
                         output logic [7:0] expv);
        int a, o, b, p;
        bit via_ptr;
        is_pm = 0; has_per = 0; per_a = 0; expv = 8'h00; via_ptr = 0;
        a = int'(m_core[8]) * 128 + off;
        if (off < 2) begin
            p = (off == 0) ? (int'(m_core[5]) * 256 + int'(m_core[4]))
                           : (int'(m_core[7]) * 256 + int'(m_core[6]));
            if (p >= 32768) begin
                is_pm = !wr;
                expv  = pm_val(p & 32767);
                return;
            end
            a = p & 4095;
            via_ptr = 1;
        end
        o = a % 128;
        b = a / 128;
        if (o < 2) begin
            expv = 8'h00;
        end else if (o < 12) begin
            if (wr) m_core[o] = (o == 8) ? (d & 8'h1F) : d;
            else    expv = m_core[o];
        end else if (o < 32) begin
            has_per = 1;
            per_a   = a;
            expv    = per_val(a);
        end else if (o < 112) begin
            if (b < GPR_BANKS) begin
                if (wr) m_gpr[b*80 + o - 32] = d;
                else    expv = m_gpr[b*80 + o - 32];
            end
        end else begin
            if (wr) m_com[o - 112] = d;
            else    expv = m_com[o - 112];
        end
        if (via_ptr && o < 2) expv = 8'h00;
    endtask

    // one access; entered and left just after a falling edge
    task automatic acc(input bit wr, input int off, input logic [7:0] d, input string rq);
        bit is_pm, has_per;
        int per_a;
        logic [7:0] expv;
        model(wr, off, d, is_pm, has_per, per_a, expv);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = 7'(off);
        acc_wdata  = d;
        #1;
        chk(per_en === has_per, rq, "per_en", int'(per_en), int'(has_per));
        if (has_per) begin
            chk(int'(per_addr) == per_a, rq, "per_addr", int'(per_addr), per_a);
            chk(per_we === wr, rq, "per_we", int'(per_we), int'(wr));
            if (wr) chk(per_wdata === d, rq, "per_wdata", int'(per_wdata), int'(d));
        end
        @(negedge clk);
        acc_valid = 1'b0;
        if (wr) begin
            chk(rd_valid === 1'b0 && stall === 1'b0, rq, "write gives no result/stall",
                int'({rd_valid, stall}), 0);
        end else if (is_pm) begin
            chk(stall === 1'b1 && rd_valid === 1'b0, "R9", "stall cycle", int'({stall, rd_valid}), 2);
            @(negedge clk);
            chk(stall === 1'b0, "R9", "stall drops", int'(stall), 0);
            chk(rd_valid === 1'b1 && rd_data === expv, rq, "pm read", int'(rd_data), int'(expv));
        end else begin
            chk(rd_valid === 1'b1, rq, "rd_valid", int'(rd_valid), 1);
            chk(rd_data === expv, rq, "rd_data", int'(rd_data), int'(expv));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=%0d cycles expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (m_core[i]) m_core[i] = 8'h00;
        foreach (m_com[i])  m_com[i]  = 8'h00;
        foreach (m_gpr[i])  m_gpr[i]  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(rd_valid === 1'b0 && stall === 1'b0 && per_en === 1'b0 && rd_data === 8'h00,
            "R10", "reset outputs", int'({rd_valid, stall, per_en, rd_data}), 0);
        acc(0, 9, 8'h00, "R10");
        acc(0, 5, 8'h00, "R10");

        // R1 per-bank general RAM
        acc(1, 8'h20, 8'hA1, "R1");
        acc(1, 8, 8'h01, "R1");
        acc(1, 8'h20, 8'hB2, "R1");
        acc(0, 8'h20, 8'h00, "R1");
        acc(1, 8, 8'h00, "R1");
        acc(0, 8'h20, 8'h00, "R1");
        acc(1, 8'h6F, 8'h3C, "R1");
        acc(0, 8'h6F, 8'h00, "R1");

        // R5 bank register width
        acc(1, 8, 8'hFF, "R5");
        acc(0, 8, 8'h00, "R5");

        // R2 core registers in every bank
        acc(1, 8, 8'h01, "R2");
        acc(1, 9, 8'h5D, "R2");
        acc(1, 3, 8'h77, "R2");
        acc(1, 8, 8'h03, "R2");
        acc(0, 9, 8'h00, "R2");
        acc(0, 3, 8'h00, "R2");
        acc(1, 11, 8'h42, "R2");
        acc(1, 8, 8'h1E, "R2");
        acc(0, 11, 8'h00, "R2");

        // R3 shared RAM
        acc(1, 8, 8'h02, "R3");
        acc(1, 8'h75, 8'hC4, "R3");
        acc(1, 8, 8'h00, "R3");
        acc(0, 8'h75, 8'h00, "R3");
        acc(1, 8, 8'h1F, "R3");
        acc(0, 8'h75, 8'h00, "R3");

        // R4 peripheral slots
        acc(1, 8, 8'h07, "R4");
        acc(1, 8'h15, 8'h99, "R4");
        acc(0, 8'h15, 8'h00, "R4");
        acc(0, 8'h0C, 8'h00, "R4");
        acc(0, 8'h1F, 8'h00, "R4");

        // R5 unimplemented general RAM
        acc(1, 8, 8'h0A, "R5");
        acc(1, 8'h30, 8'h66, "R5");
        acc(0, 8'h30, 8'h00, "R5");

        // R6 pointer access to data memory
        acc(1, 4, 8'h23, "R6");
        acc(1, 5, 8'h01, "R6");
        acc(1, 0, 8'h8E, "R6");
        acc(0, 0, 8'h00, "R6");
        acc(1, 8, 8'h02, "R6");
        acc(0, 8'h23, 8'h00, "R6");
        acc(1, 6, 8'h8C, "R6");
        acc(1, 7, 8'h00, "R6");
        acc(0, 1, 8'h00, "R6");
        acc(1, 1, 8'h12, "R6");
        acc(1, 6, 8'h80, "R6");
        acc(1, 7, 8'h0F, "R6");
        acc(0, 1, 8'h00, "R6");
        acc(1, 1, 8'h55, "R6");
        acc(0, 1, 8'h00, "R6");
        acc(1, 6, 8'h09, "R6");
        acc(1, 7, 8'h0E, "R6");
        acc(1, 1, 8'h0B, "R6");
        acc(0, 9, 8'h00, "R6");

        // R7 program memory read, R9 stall
        acc(1, 4, 8'h45, "R7");
        acc(1, 5, 8'hB3, "R7");
        acc(0, 0, 8'h00, "R7");
        acc(1, 5, 8'hFF, "R7");
        acc(0, 0, 8'h00, "R7");

        // R9 request during the stall is ignored
        acc(1, 8, 8'h00, "R9");
        acc(1, 8'h70, 8'h11, "R9");
        acc(1, 4, 8'h45, "R9");
        acc(1, 5, 8'h83, "R9");
        begin
            bit is_pm, has_per;
            int per_a;
            logic [7:0] expv;
            model(0, 0, 8'h00, is_pm, has_per, per_a, expv);
            acc_valid = 1'b1; acc_write = 1'b0; acc_offset = 7'd0;
            @(negedge clk);
            acc_write = 1'b1; acc_offset = 7'h70; acc_wdata = 8'hEE;
            chk(stall === 1'b1, "R9", "stall high", int'(stall), 1);
            @(negedge clk);
            acc_valid = 1'b0;
            chk(rd_valid === 1'b1 && rd_data === expv, "R9", "pm data after stall",
                int'(rd_data), int'(expv));
        end
        acc(0, 8'h70, 8'h00, "R9");

        // R8 write through program-memory pointer is dropped
        acc(1, 8, 8'h06, "R8");
        acc(1, 8'h45, 8'h3A, "R8");
        acc(1, 0, 8'hD7, "R8");
        acc(0, 8'h45, 8'h00, "R8");
        acc(1, 4, 8'h0C, "R8");
        acc(1, 5, 8'h80, "R8");
        acc(1, 0, 8'hD7, "R8");
        acc(1, 5, 8'h00, "R8");
        acc(0, 0, 8'h00, "R8");

        // random mix against the model (R1..R10)
        for (int k = 0; k < 600; k++) begin
            int off;
            bit wr;
            off = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 11))
                                              : int'($urandom_range(0, 127));
            wr  = $urandom_range(0, 1) == 1;
            acc(wr, off, 8'($urandom), "R1");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule